// File: doc/BRIEF.md
# Data/Strobe Serial Link Repeater

This block sits on a two-wire serial link in which one wire carries the data and the other wire, the strobe, toggles only when the data does not. A new bit is therefore marked by a transition on exactly one of the two wires. The block samples both wires with a fast system clock that runs at least four times the bit rate. It passes them through a synchronizer and treats every transition as one received bit. The recovered bit is handed to local packet logic with a one-cycle valid pulse.

Each received transition also drives one bit out on a regenerated data/strobe pair, so that devices can be chained. The bit sent out is the one received two transitions earlier. Right after reset the line is empty, so the first two transitions send filler zeros. Output happens only on input transitions. When the upstream link goes quiet, the output freezes on its last bit and does not drain. A chain of N repeaters therefore needs 2×N trailing bits after a packet before the last device has passed the packet on.

Top module: `ds_link_repeater`

## Requirements
- R1: While reset is low, ds_dout, ds_sout, rx_bit and rx_valid are 0, and the two-bit delay line is cleared.
- R2: Each change of the input wire pair makes rx_valid high for exactly one clock cycle, three rising clock edges after the change is applied, with rx_bit equal to the ds_din level after that change.
- R3: On each received transition, ds_dout takes the bit received two transitions earlier, on the same cycle that rx_valid is high.
- R4: The first two transitions after reset emit filler bits of value 0 on ds_dout.
- R5: Each emitted bit toggles exactly one of ds_dout or ds_sout. ds_dout XOR ds_sout is 0 after reset and alternates with every emitted bit.
- R6: With no input transition, ds_dout and ds_sout hold their values and rx_valid stays low, however long the link is idle.
- R7: When both input wires change in the same sample, this counts as one received bit whose value is the new ds_din level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, at least 4× the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ds_din | input | 1 | Incoming data wire |
| ds_sin | input | 1 | Incoming strobe wire |
| ds_dout | output | 1 | Regenerated outgoing data wire |
| ds_sout | output | 1 | Regenerated outgoing strobe wire |
| rx_bit | output | 1 | Most recently recovered bit |
| rx_valid | output | 1 | One-cycle pulse when rx_bit is new |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer and a lag of two bits. These defaults put the three-cycle input-to-output latency and the two-entry filler window directly at the ports. Bits are sent at the minimum spacing of four clocks and at wider spacings. Long idle gaps, runs of equal bits that exercise the strobe wire, a simultaneous change of both wires, and a reset in the middle of traffic that reopens the filler window are all covered.

// File: rtl/ds_link_pkg.sv
package ds_link_pkg;

  typedef struct packed {
    logic d;
    logic s;
  } ds_pair_t;

  // A new bit is signalled when either wire differs from its previous sample.
  function automatic logic ds_edge(input ds_pair_t now_v, input ds_pair_t prev_v);
    return (now_v.d ^ prev_v.d) | (now_v.s ^ prev_v.s);
  endfunction

  // Strobe for the next emitted bit: the new pair parity is the inverse of
  // the old parity, so exactly one wire changes.
  function automatic logic ds_next_strobe(input logic d_new, input logic d_old,
                                          input logic s_old);
    return d_new ^ ~(d_old ^ s_old);
  endfunction

endpackage

// File: rtl/ds_sync.sv
module ds_sync
  import ds_link_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ds_pair_t raw,
  output ds_pair_t synced,
  output ds_pair_t held
);
  ds_pair_t chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      held <= '0;
    end else begin
      chain[0] <= raw;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      held <= chain[STAGES-1];
    end
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/ds_bit_recover.sv
module ds_bit_recover
  import ds_link_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ds_pair_t synced,
  input  ds_pair_t held,
  output logic     edge_seen,
  output logic     bit_now,
  output logic     rx_bit,
  output logic     rx_valid
);
  assign edge_seen = ds_edge(synced, held);
  assign bit_now   = synced.d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bit   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= edge_seen;
      if (edge_seen) rx_bit <= bit_now;
    end
  end
endmodule

// File: rtl/ds_lag_line.sv
module ds_lag_line #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_in,
  output logic tap_bit
);
  logic [LAG-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (shift_en) begin
      line_q[0] <= bit_in;
      for (int i = 1; i < LAG; i++) line_q[i] <= line_q[i-1];
    end
  end

  // Oldest entry, read before the shift: the bit from LAG transitions ago.
  assign tap_bit = line_q[LAG-1];
endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
  import ds_link_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic bit_in,
  output logic dout,
  output logic sout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      sout <= 1'b0;
    end else if (fire) begin
      dout <= bit_in;
      sout <= ds_next_strobe(bit_in, dout, sout);
    end
  end
endmodule

// File: rtl/ds_link_repeater.sv
module ds_link_repeater
  import ds_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LAG         = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ds_din,
  input  logic ds_sin,
  output logic ds_dout,
  output logic ds_sout,
  output logic rx_bit,
  output logic rx_valid
);
  ds_pair_t raw_w;
  ds_pair_t synced_w;
  ds_pair_t held_w;
  logic     edge_seen;
  logic     bit_now;
  logic     tap_bit;

  assign raw_w.d = ds_din;
  assign raw_w.s = ds_sin;

  ds_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (raw_w),
    .synced (synced_w),
    .held   (held_w)
  );

  ds_bit_recover u_recover (
    .clk       (clk),
    .rst_n     (rst_n),
    .synced    (synced_w),
    .held      (held_w),
    .edge_seen (edge_seen),
    .bit_now   (bit_now),
    .rx_bit    (rx_bit),
    .rx_valid  (rx_valid)
  );

  ds_lag_line #(.LAG(LAG)) u_lag (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (edge_seen),
    .bit_in   (bit_now),
    .tap_bit  (tap_bit)
  );

  ds_tx_encoder u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (edge_seen),
    .bit_in (tap_bit),
    .dout   (ds_dout),
    .sout   (ds_sout)
  );
endmodule

// File: rtl/ds_link_repeater_chk.sv
module ds_link_repeater_chk #(
  parameter int LAG = 2
) (
  input logic clk,
  input logic rst_n,
  input logic edge_seen,
  input logic ds_dout,
  input logic ds_sout,
  input logic rx_bit,
  input logic rx_valid
);
  logic h1, h2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= 1'b0;
      h2 <= 1'b0;
    end else if (rx_valid) begin
      h1 <= rx_bit;
      h2 <= h1;
    end
  end

  assert_valid_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> rx_valid);

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_one_wire_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> ($countones({ds_dout ^ $past(ds_dout), ds_sout ^ $past(ds_sout)}) == 1));

  assert_hold_no_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_seen |=> ($stable(ds_dout) && $stable(ds_sout) && !rx_valid));

  generate
    if (LAG == 2) begin : g_lag2
      // Covers R3 and the filler zeros of R4 (history resets to 0).
      assert_lag_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (ds_dout == h2));
    end
  endgenerate
endmodule

bind ds_link_repeater ds_link_repeater_chk #(.LAG(LAG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .edge_seen (edge_seen),
  .ds_dout   (ds_dout),
  .ds_sout   (ds_sout),
  .rx_bit    (rx_bit),
  .rx_valid  (rx_valid)
);

// File: tb/test_ds_link_repeater.sv
`timescale 1ns/1ps
module test_ds_link_repeater;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din_r = 1'b0;
  logic sin_r = 1'b0;
  logic ds_dout, ds_sout, rx_bit, rx_valid;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  int event_at = -1;
  logic pend_bit = 1'b0;

  // reference model state
  logic got_q [$];
  int   emits = 0;
  logic exp_d = 1'b0, exp_s = 1'b0, exp_v = 1'b0, exp_b = 1'b0;

  always #2.5 clk = ~clk;

  ds_link_repeater i_ds_link_repeater (
    .clk      (clk),
    .rst_n    (rst_n),
    .ds_din   (din_r),
    .ds_sin   (sin_r),
    .ds_dout  (ds_dout),
    .ds_sout  (ds_sout),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cycle);
    end
  endtask

  // Reference model: a bit driven at count c is seen at the ports after edge c+3.
  always @(posedge clk) begin
    cycle++;
    if (!rst_n) begin
      got_q.delete();
      emits = 0;
      exp_d = 0; exp_s = 0; exp_v = 0; exp_b = 0;
      event_at = -1;
    end else begin
      exp_v = 0;
      if (cycle == event_at) begin
        logic emitted;
        got_q.push_back(pend_bit);
        emitted = (got_q.size() >= 3) ? got_q[got_q.size()-3] : 1'b0;
        emits++;
        exp_d = emitted;
        exp_s = emitted ^ emits[0];
        exp_v = 1;
        exp_b = pend_bit;
      end
    end
    if (cycle == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog R2 act=%0d exp=%0d", cycle, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(rx_valid == exp_v, "R2 rx_valid", rx_valid, exp_v);
      if (exp_v) check(rx_bit == exp_b, "R2 rx_bit", rx_bit, exp_b);
      check(ds_dout == exp_d, "R3 ds_dout", ds_dout, exp_d);
      check(ds_sout == exp_s, "R5 ds_sout", ds_sout, exp_s);
    end
  end

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk);
    if (b != din_r) din_r = ~din_r;
    else            sin_r = ~sin_r;
    pend_bit = b;
    event_at = cycle + 3;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic send_both(input int gap);
    @(negedge clk);
    din_r = ~din_r;
    sin_r = ~sin_r;
    pend_bit = din_r;
    event_at = cycle + 3;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    din_r = 0;
    sin_r = 0;
    repeat (4) @(negedge clk);
    check({ds_dout, ds_sout, rx_bit, rx_valid} == 4'b0, "R1 reset state",
          {ds_dout, ds_sout, rx_bit, rx_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] lfsr;
    logic hd, hs;
    repeat (3) @(negedge clk);
    check({ds_dout, ds_sout, rx_bit, rx_valid} == 4'b0, "R1 initial reset",
          {ds_dout, ds_sout, rx_bit, rx_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4: two filler bits even though ones are received
    send_bit(1, 4);
    check(ds_dout == 0, "R4 filler first", ds_dout, 0);
    send_bit(1, 4);
    check(ds_dout == 0, "R4 filler second", ds_dout, 0);
    send_bit(0, 4);
    check(ds_dout == 1, "R3 lag two bits", ds_dout, 1);

    // alternating pattern at minimum spacing
    for (int i = 0; i < 12; i++) send_bit(i[0], 4);

    // R6: long idle, outputs frozen
    hd = ds_dout; hs = ds_sout;
    repeat (60) @(negedge clk);
    check(ds_dout == hd && ds_sout == hs, "R6 frozen when idle",
          {ds_dout, ds_sout}, {hd, hs});
    check(rx_valid == 0, "R6 no valid when idle", rx_valid, 0);

    // runs of equal bits toggle the strobe wire
    for (int i = 0; i < 6; i++) send_bit(0, 7);
    for (int i = 0; i < 5; i++) send_bit(1, 5);

    // R7: both wires change together -> one bit of new data level
    send_both(4);
    check(rx_bit == din_r, "R7 simultaneous change", rx_bit, din_r);
    send_bit(0, 4);
    send_bit(1, 4);

    // reset in mid traffic reopens the filler window (R1, R4)
    do_reset();
    send_bit(1, 4);
    send_bit(1, 4);
    check(ds_dout == 0, "R4 filler after reset", ds_dout, 0);

    // pseudo-random stream with varied spacing
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send_bit(lfsr[0], 4 + int'(lfsr[2:1]));
    end
    repeat (10) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule